// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block collects the four interrupt causes of a UART and reports the one with the highest priority: a change on a modem input, the transmit holding buffer going empty, a received byte becoming available, and a receive line error. Each cause is held in its own pending latch. The latch is set by an event from the serial side and cleared by the register access that services it. An enable register with five bits masks each cause separately. Its top bit does not mask an interrupt. It drives the enable for transmit DMA requests.

The identification value is 16 bits wide. Bit 0 is a pending flag that is low when an interrupt is pending. Bits [2:1] carry the code of the reported cause. The interrupt output is the inverse of that flag. Both outputs follow the masked latches combinationally. The bus decode outside the block turns register accesses into single-cycle strobes for this block. The serial shifter supplies the event inputs.

Top module: `uart_irq_id`

## Requirements
- R1: The enable register has five bits and resets to 0. It loads `enWrData` on a cycle where `enWr` is high. Bit 4 of the register drives `dmaTxEn` directly.
- R2: A modem-change pending latch is set on any cycle where at least one of the four `modemDelta` bits is high.
- R3: After reset, `iid` reads 0x0001. Bits [15:3] always read 0. Bit 0 is 1 when no enabled cause is pending and 0 when one is pending.
- R4: The codes in `iid[2:1]` are 00 for modem change, 01 for transmit empty, 10 for receive data, and 11 for line error. When several enabled causes are pending, the reported code follows the priority line error > receive data > transmit empty > modem change.
- R5: A cause is reported only while its enable bit is 1. The enable bits are: bit 0 for receive data, bit 1 for transmit empty, bit 2 for line error, bit 3 for modem change. A latch set while its enable is 0 stays pending, and the cause is reported as soon as its enable is set.
- R6: The modem-change latch clears on `msrRd`. The receive-data latch clears on `rxRd`. The line-error latch clears on `lsrRd`.
- R7: The transmit-empty latch clears on `txWr`. It also clears on `iidRd` when, in that same cycle, `iid[0]` is 0 and `iid[2:1]` is 01. On an `iidRd` while another code is reported, the transmit-empty latch is left pending.
- R8: The transmit-empty latch is set only in a cycle where `txEmpty` is high after having been low in the previous cycle. A `txEmpty` that stays high does not set the latch again after it has been cleared.
- R9: When a set event and a clear strobe hit the same latch in the same cycle, the latch ends up pending.
- R10: `irq` is always the inverse of `iid[0]` in the same cycle. When no enabled cause is pending, `iid[2:1]` reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enWr | input | 1 | Write strobe for the enable register |
| enWrData | input | 5 | Value loaded into the enable register |
| modemDelta | input | 4 | Modem-change event bits |
| txEmpty | input | 1 | Transmit holding buffer empty status (level) |
| rxEvt | input | 1 | Receive data available event (pulse) |
| lineEvt | input | 1 | Receive line error event (pulse) |
| iidRd | input | 1 | Identification register read strobe |
| txWr | input | 1 | Transmit data register write strobe |
| rxRd | input | 1 | Receive data register read strobe |
| lsrRd | input | 1 | Line status register read strobe |
| msrRd | input | 1 | Modem status register read strobe |
| iid | output | 16 | Identification value: pending flag and cause code |
| irq | output | 1 | Interrupt request, active high |
| dmaTxEn | output | 1 | Transmit DMA request enable |

## Verification
Two kinds of event can meet in one cycle. A serial-side event can arrive in the cycle where software's clearing access lands on the same latch. The bench provokes this by pulsing `rxEvt` together with `rxRd`, and a `modemDelta` bit together with `msrRd`. The cause must still be reported on the following cycle. The other collision is an identification read arriving while transmit-empty is pending alongside a cause of higher priority. That read must leave the transmit-empty latch set, and this is judged after the line status read exposes code 01.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_W   = 2;

  // enable register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_DMA   = 4;

  // source index equals reported code; higher index wins
  typedef enum logic [SRC_W-1:0] {
    SRC_MODEM = 2'd0,
    SRC_TX    = 2'd1,
    SRC_RX    = 2'd2,
    SRC_LINE  = 2'd3
  } srcCode_e;

  // packed MSB first so bit n corresponds to source code n
  typedef struct packed {
    logic line;
    logic rx;
    logic tx;
    logic modem;
  } clrStrobes_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             iidRd,
  input  logic             txWr,
  input  logic             rxRd,
  input  logic             lsrRd,
  input  logic             msrRd,
  input  logic [SRC_W-1:0] curCode,
  input  logic             pendN,
  output clrStrobes_t      clr
);
  logic txReported;

  always_comb begin
    txReported = ~pendN & (curCode == SRC_TX);
    clr.modem  = msrRd;
    clr.rx     = rxRd;
    clr.line   = lsrRd;
    clr.tx     = txWr | (iidRd & txReported);
  end
endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int MODEM_BITS = 4,
  parameter int EN_W       = 5,
  parameter int IID_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enWr,
  input  logic [EN_W-1:0]       enWrData,
  input  logic [MODEM_BITS-1:0] modemDelta,
  input  logic                  txEmpty,
  input  logic                  rxEvt,
  input  logic                  lineEvt,
  input  clrStrobes_t           clr,
  output logic [IID_W-1:0]      iid,
  output logic                  irq,
  output logic                  dmaTxEn,
  output logic [SRC_W-1:0]      curCode,
  output logic                  pendN
);
  logic [EN_W-1:0]    enReg;
  logic               txEmptyQ;
  logic [NUM_SRC-1:0] setVec, clrVec, pendQ, srcEn, masked;
  logic               anyPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      txEmptyQ <= 1'b0;
    end else begin
      if (enWr) enReg <= enWrData;
      txEmptyQ <= txEmpty;
    end
  end

  always_comb begin
    setVec            = '0;
    setVec[SRC_MODEM] = |modemDelta;
    setVec[SRC_TX]    = txEmpty & ~txEmptyQ;
    setVec[SRC_RX]    = rxEvt;
    setVec[SRC_LINE]  = lineEvt;
    clrVec            = clr;
    srcEn             = '0;
    srcEn[SRC_MODEM]  = enReg[EN_MODEM];
    srcEn[SRC_TX]     = enReg[EN_TX];
    srcEn[SRC_RX]     = enReg[EN_RX];
    srcEn[SRC_LINE]   = enReg[EN_LINE];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          pendQ[g] <= 1'b0;
      else if (setVec[g]) pendQ[g] <= 1'b1;
      else if (clrVec[g]) pendQ[g] <= 1'b0;
    end
  end

  assign masked = pendQ & srcEn;

  always_comb begin
    curCode = '0;
    anyPend = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (masked[i]) begin
        curCode = SRC_W'(i);
        anyPend = 1'b1;
      end
    end
    pendN          = ~anyPend;
    iid            = '0;
    iid[0]         = pendN;
    iid[SRC_W:1]   = curCode;
    irq            = anyPend;
    dmaTxEn        = enReg[EN_DMA];
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int MODEM_BITS = 4,
  parameter int EN_W       = 5,
  parameter int IID_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enWr,
  input  logic [EN_W-1:0]       enWrData,
  input  logic [MODEM_BITS-1:0] modemDelta,
  input  logic                  txEmpty,
  input  logic                  rxEvt,
  input  logic                  lineEvt,
  input  logic                  iidRd,
  input  logic                  txWr,
  input  logic                  rxRd,
  input  logic                  lsrRd,
  input  logic                  msrRd,
  output logic [IID_W-1:0]      iid,
  output logic                  irq,
  output logic                  dmaTxEn
);
  clrStrobes_t      clr;
  logic [SRC_W-1:0] curCode;
  logic             pendN;

  uart_irq_ctrl u_ctrl (
    .iidRd  (iidRd),
    .txWr   (txWr),
    .rxRd   (rxRd),
    .lsrRd  (lsrRd),
    .msrRd  (msrRd),
    .curCode(curCode),
    .pendN  (pendN),
    .clr    (clr)
  );

  uart_irq_datapath #(
    .MODEM_BITS(MODEM_BITS),
    .EN_W      (EN_W),
    .IID_W     (IID_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .enWr      (enWr),
    .enWrData  (enWrData),
    .modemDelta(modemDelta),
    .txEmpty   (txEmpty),
    .rxEvt     (rxEvt),
    .lineEvt   (lineEvt),
    .clr       (clr),
    .iid       (iid),
    .irq       (irq),
    .dmaTxEn   (dmaTxEn),
    .curCode   (curCode),
    .pendN     (pendN)
  );
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk #(
  parameter int IID_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enWr,
  input logic             txEmpty,
  input logic             rxEvt,
  input logic             lineEvt,
  input logic             txWr,
  input logic             rxRd,
  input logic             lsrRd,
  input logic [IID_W-1:0] iid,
  input logic             dmaTxEn
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    iid[IID_W-1:3] == '0); // R3

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    iid[0] |-> iid[2:1] == 2'b00); // R10

  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !enWr |=> $stable(dmaTxEn)); // R1

  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rxRd && !rxEvt) |=> iid[2:1] != 2'b10); // R6

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRd && !lineEvt) |=> iid[2:1] != 2'b11); // R6

  AST_TXWR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (txWr && !txEmpty) |=> iid[2:1] != 2'b01); // R7
endmodule

bind uart_irq_id uart_irq_id_chk #(.IID_W(IID_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .enWr   (enWr),
  .txEmpty(txEmpty),
  .rxEvt  (rxEvt),
  .lineEvt(lineEvt),
  .txWr   (txWr),
  .rxRd   (rxRd),
  .lsrRd  (lsrRd),
  .iid    (iid),
  .dmaTxEn(dmaTxEn)
);

// File: tb/uart_irq_id_tb.sv
module uart_irq_id_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        enWr;
  logic [4:0]  enWrData;
  logic [3:0]  modemDelta;
  logic        txEmpty, rxEvt, lineEvt;
  logic        iidRd, txWr, rxRd, lsrRd, msrRd;
  logic [15:0] iid;
  logic        irq, dmaTxEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_id u_dut (
    .clk(clk), .rstN(rstN), .enWr(enWr), .enWrData(enWrData),
    .modemDelta(modemDelta), .txEmpty(txEmpty), .rxEvt(rxEvt),
    .lineEvt(lineEvt), .iidRd(iidRd), .txWr(txWr), .rxRd(rxRd),
    .lsrRd(lsrRd), .msrRd(msrRd), .iid(iid), .irq(irq), .dmaTxEn(dmaTxEn)
  );

  // expected value from enable register bits and pending set (index = code)
  function automatic logic [15:0] expIid(input logic [3:0] en, input logic [3:0] pend);
    logic [3:0] srcEn, m;
    logic [15:0] r;
    srcEn = {en[2], en[0], en[1], en[3]};
    m = srcEn & pend;
    r = 16'h0001;
    for (int i = 0; i < 4; i++)
      if (m[i]) r = {13'b0, 2'(i), 1'b0};
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (iid !== exp || irq !== ~exp[0]) begin
      errors++;
      $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b", req, iid, irq, exp, ~exp[0]);
    end
  endtask

  task automatic idle();
    enWr = 0; enWrData = '0; modemDelta = '0; rxEvt = 0; lineEvt = 0;
    iidRd = 0; txWr = 0; rxRd = 0; lsrRd = 0; msrRd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    idle(); txEmpty = 0; rstN = 0;
    @(negedge clk);
    rstN = 1;
    #1;
  endtask

  task automatic writeEn(input logic [4:0] v);
    @(negedge clk); enWr = 1; enWrData = v;
    step();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; txEmpty = 0; idle();
    repeat (2) @(negedge clk);
    rstN = 1; #1;
    // R3 reset state
    check("R3 reset", 16'h0001);
    checks++;
    if (dmaTxEn !== 1'b0) begin errors++; $display("FAIL R1: dmaTxEn=%b expected 0", dmaTxEn); end

    // R1 DMA enable bit
    writeEn(5'b10000);
    checks++;
    if (dmaTxEn !== 1'b1) begin errors++; $display("FAIL R1: dmaTxEn=%b expected 1", dmaTxEn); end
    check("R1 dma only, no irq", 16'h0001);

    // R4 R5 R10 sweep of enables against pending sets
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 16; p++) begin
        doReset();
        writeEn({1'b0, 4'(e)});
        @(negedge clk);
        modemDelta = p[0] ? 4'b0100 : 4'b0000;
        txEmpty    = p[1];
        rxEvt      = p[2];
        lineEvt    = p[3];
        step();
        txEmpty = 0;
        check("R4 R5 R10 sweep", expIid(4'(e), 4'(p)));
      end
    end

    // R2 each modem delta bit alone; R6 msrRd clears
    for (int b = 0; b < 4; b++) begin
      doReset();
      writeEn(5'b01000);
      @(negedge clk); modemDelta = 4'(1 << b);
      step();
      check("R2 modem bit", 16'h0000);
      @(negedge clk); msrRd = 1;
      step();
      check("R6 modem clear", 16'h0001);
    end

    // R5 late enable reveals latched source
    doReset();
    @(negedge clk); rxEvt = 1;
    step();
    check("R5 masked rx", 16'h0001);
    writeEn(5'b00001);
    check("R5 late enable rx", 16'h0004);
    @(negedge clk); rxRd = 1;
    step();
    check("R6 rx clear", 16'h0001);

    // R9 set and clear in same cycle
    @(negedge clk); rxEvt = 1; rxRd = 1;
    step();
    check("R9 rx set wins", 16'h0004);
    doReset();
    writeEn(5'b01000);
    @(negedge clk); modemDelta = 4'b0001; msrRd = 1;
    step();
    check("R9 modem set wins", 16'h0000);

    // R7 R8 transmit empty clearing
    doReset();
    writeEn(5'b01111);
    @(negedge clk); txEmpty = 1;
    step();
    check("R8 tx rise", 16'h0002);
    @(negedge clk); iidRd = 1;
    step();
    check("R7 iid read clears tx", 16'h0001);
    step(); step();
    check("R8 level high no reassert", 16'h0001);
    @(negedge clk); txEmpty = 0;
    step();
    @(negedge clk); txEmpty = 1;
    step();
    check("R8 rearm on new rise", 16'h0002);
    @(negedge clk); txEmpty = 0; txWr = 1;
    step();
    check("R7 txWr clears", 16'h0001);

    // R7 iid read while higher source reported keeps tx
    @(negedge clk); txEmpty = 1; lineEvt = 1;
    step();
    check("R4 line over tx", 16'h0006);
    @(negedge clk); iidRd = 1;
    step();
    check("R7 iid read keeps tx", 16'h0006);
    @(negedge clk); lsrRd = 1;
    step();
    check("R7 tx still pending", 16'h0002);
    @(negedge clk); iidRd = 1;
    step();
    check("R7 now cleared", 16'h0001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule